// File: doc/BRIEF.md
# Task Base Relocation Unit

This unit sits on the address path between a 32-bit core and memory. It gives every task a private logical address space. A task's space is placed inside the shared physical space by adding a per-task base value. A single translation flag selects between two modes. With the flag clear, the unit runs untranslated task-zero (operating system) mode, and addresses pass straight through. With the flag set, every access is offset by the task base register.

The core can exchange the base register with a general register in one operation. That operation returns the old base value and loads a new one. While translation is on, the access after the swap already runs inside the other task's space. The swap never writes to memory.

A trap drops the unit into task-zero mode and saves the prior flag in a shadow bit. A return control restores the flag from that bit. Two build-time options exist:
- The upper half of the logical space can be left untranslated, so that fixed devices and shared tables stay at known physical addresses.
- A supervisor option suppresses the swap and the flag write while translation is on, and reports each suppressed attempt.

Top module: `task_reloc_unit`

## Requirements
- R1: After reset the translation flag reads 0, the base register reads 0 on `xtr_rdata`, and `priv_viol` is 0.
- R2: While `t_mode` is 0, `phys_addr` equals `log_addr` in the same cycle, and `phys_req` follows `acc_req` in the same cycle.
- R3: While `t_mode` is 1, `phys_addr` equals (`log_addr` + base) modulo 2^32 in the same cycle as the access. Any carry out of bit 31 is dropped.
- R4: `xtr_rdata` always shows the current base. When a swap (`xtr_req`=1) is permitted, the base takes `xtr_wdata` at the clock edge. From the next cycle, both the base shown and translation use the new value.
- R5: A trap (`trap_req`=1) makes `t_mode` 0 from the next cycle and saves the prior flag in the shadow bit. The base is unchanged unless a swap occurs in the same cycle.
- R6: A return (`rti_req`=1 with no trap) sets `t_mode` from the shadow bit in the next cycle.
- R7: A permitted flag write (`mode_wr`=1 with no trap or return in the same cycle) sets `t_mode` to `mode_val` in the next cycle.
- R8: With UPPER_BYPASS=1, a logical address whose bit 31 is 1 passes through untranslated even while `t_mode` is 1. With UPPER_BYPASS=0 (the default), such an address is translated.
- R9: With SUPERVISOR=1 and `t_mode`=1, a swap or flag write changes nothing, and `priv_viol` is 1 for exactly the following cycle. With SUPERVISOR=0 (the default), or while `t_mode` is 0, `priv_viol` stays 0 and both operations take effect.
- R10: When several controls arrive in one cycle, the trap wins over the return, and the return wins over the flag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access strobe from the core |
| log_addr | input | 32 | Logical address from the core |
| phys_req | output | 1 | Access strobe to memory |
| phys_addr | output | 32 | Physical address to memory |
| xtr_req | input | 1 | Swap base register with `xtr_wdata` |
| xtr_wdata | input | 32 | New base value from a general register |
| xtr_rdata | output | 32 | Current base value, captured by the core on a swap |
| trap_req | input | 1 | Trap entry into task-zero mode |
| rti_req | input | 1 | Return from trap, restores the flag |
| mode_wr | input | 1 | Write the translation flag |
| mode_val | input | 1 | Value for the flag write |
| t_mode | output | 1 | Current translation flag |
| priv_viol | output | 1 | One-cycle pulse after a suppressed operation |

## Verification
The physical address and access strobe are combinational, so they are due in the same cycle the address is presented, and they are computed from the flag and base values as they stood after the previous edge. Swaps, traps, returns and flag writes take effect at the next clock edge. Their results on `t_mode` and `xtr_rdata`, and the `priv_viol` pulse, are therefore due exactly one cycle after the request. The driver applies each step's inputs on the falling edge and queues the values expected for that same cycle. It then advances its model across the coming edge. The monitor samples 1 ns after that falling edge, so every comparison sees both the freshly driven combinational path and the state from the last rising edge. Two instances run side by side: one with the default build and one with both options enabled.

// File: rtl/trl_pkg.sv
package trl_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_TRAP  = 2'd1,
      ACT_RET   = 2'd2,
      ACT_WRITE = 2'd3
   } mode_act_e;

   function automatic mode_act_e pick_action(input logic trap, input logic ret,
                                             input logic wr_ok);
      if (trap)       return ACT_TRAP;
      else if (ret)   return ACT_RET;
      else if (wr_ok) return ACT_WRITE;
      else            return ACT_HOLD;
   endfunction

endpackage

// File: rtl/trl_mode_ctrl.sv
module trl_mode_ctrl
   import trl_pkg::*;
#(
   parameter bit SUPERVISOR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trap_req,
   input  logic rti_req,
   input  logic mode_wr,
   input  logic mode_val,
   input  logic xtr_req,
   output logic t_q,
   output logic shadow_q,
   output logic swap_ok,
   output logic viol_q
);

   logic      gated;
   logic      viol_d;
   mode_act_e act;

   generate
      if (SUPERVISOR) begin : g_sup
         assign gated  = t_q;
         assign viol_d = t_q & (xtr_req | mode_wr);
      end else begin : g_open
         assign gated  = 1'b0;
         assign viol_d = 1'b0;
      end
   endgenerate

   assign swap_ok = xtr_req & ~gated;
   assign act     = pick_action(trap_req, rti_req, mode_wr & ~gated);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q      <= 1'b0;
         shadow_q <= 1'b0;
         viol_q   <= 1'b0;
      end else begin
         viol_q <= viol_d;
         unique case (act)
            ACT_TRAP: begin
               shadow_q <= t_q;
               t_q      <= 1'b0;
            end
            ACT_RET:   t_q <= shadow_q;
            ACT_WRITE: t_q <= mode_val;
            default:   t_q <= t_q;
         endcase
      end
   end

endmodule

// File: rtl/trl_base_reg.sv
module trl_base_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swap_en,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] base_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q <= '0;
      else if (swap_en) base_q <= wdata;
   end

endmodule

// File: rtl/trl_xlate.sv
module trl_xlate #(
   parameter int ADDR_W       = 32,
   parameter bit UPPER_BYPASS = 1'b0
) (
   input  logic              t_on,
   input  logic [ADDR_W-1:0] base,
   input  logic              req_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              req_out,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int TOP = ADDR_W - 1;

   logic              use_base;
   logic [ADDR_W-1:0] sum;

   generate
      if (UPPER_BYPASS) begin : g_split
         assign use_base = t_on & ~addr_in[TOP];
      end else begin : g_full
         assign use_base = t_on;
      end
   endgenerate

   assign sum      = addr_in + base;
   assign addr_out = use_base ? sum : addr_in;
   assign req_out  = req_in;

endmodule

// File: rtl/task_reloc_unit.sv
module task_reloc_unit #(
   parameter int ADDR_W       = 32,
   parameter bit UPPER_BYPASS = 1'b0,
   parameter bit SUPERVISOR   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_req,
   input  logic [ADDR_W-1:0] log_addr,
   output logic              phys_req,
   output logic [ADDR_W-1:0] phys_addr,
   input  logic              xtr_req,
   input  logic [ADDR_W-1:0] xtr_wdata,
   output logic [ADDR_W-1:0] xtr_rdata,
   input  logic              trap_req,
   input  logic              rti_req,
   input  logic              mode_wr,
   input  logic              mode_val,
   output logic              t_mode,
   output logic              priv_viol
);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("task_reloc_unit: ADDR_W must be at least 2");
      end
   endgenerate

   logic              t_shadow;
   logic              swap_ok;
   logic [ADDR_W-1:0] base_q;

   trl_mode_ctrl #(.SUPERVISOR(SUPERVISOR)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .trap_req (trap_req),
      .rti_req  (rti_req),
      .mode_wr  (mode_wr),
      .mode_val (mode_val),
      .xtr_req  (xtr_req),
      .t_q      (t_mode),
      .shadow_q (t_shadow),
      .swap_ok  (swap_ok),
      .viol_q   (priv_viol)
   );

   trl_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .swap_en (swap_ok),
      .wdata   (xtr_wdata),
      .base_q  (base_q)
   );

   trl_xlate #(.ADDR_W(ADDR_W), .UPPER_BYPASS(UPPER_BYPASS)) u_xlate (
      .t_on     (t_mode),
      .base     (base_q),
      .req_in   (acc_req),
      .addr_in  (log_addr),
      .req_out  (phys_req),
      .addr_out (phys_addr)
   );

   assign xtr_rdata = base_q;

endmodule

// File: rtl/trl_chk.sv
module trl_chk #(
   parameter int ADDR_W       = 32,
   parameter bit UPPER_BYPASS = 1'b0,
   parameter bit SUPERVISOR   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] log_addr,
   input logic [ADDR_W-1:0] phys_addr,
   input logic              xtr_req,
   input logic [ADDR_W-1:0] xtr_wdata,
   input logic [ADDR_W-1:0] xtr_rdata,
   input logic              trap_req,
   input logic              rti_req,
   input logic              mode_wr,
   input logic              t_mode,
   input logic              t_shadow,
   input logic              priv_viol
);

   localparam int TOP = ADDR_W - 1;

   logic [ADDR_W-1:0] want_sum;
   logic              locked;
   assign want_sum = log_addr + xtr_rdata;
   assign locked   = SUPERVISOR & t_mode;

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !t_mode |-> phys_addr == log_addr); // R2

   AST_RELOCATE: assert property (@(posedge clk) disable iff (!rst_n)
      (t_mode && !(UPPER_BYPASS && log_addr[TOP])) |-> phys_addr == want_sum); // R3

   AST_UPPER_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (UPPER_BYPASS && log_addr[TOP]) |-> phys_addr == log_addr); // R8

   AST_SWAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (xtr_req && !locked) |=> xtr_rdata == $past(xtr_wdata)); // R4

   AST_TRAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> !t_mode); // R5

   AST_TRAP_KEEP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !xtr_req) |=> $stable(xtr_rdata)); // R5

   AST_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_req && !trap_req) |=> t_mode == $past(t_shadow)); // R6

   AST_SUPPRESS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && (xtr_req || mode_wr)) |=> priv_viol); // R9

   AST_SUPPRESS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && xtr_req) |=> $stable(xtr_rdata)); // R9

   AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && rti_req) |=> t_shadow == $past(t_mode)); // R10

endmodule

bind task_reloc_unit trl_chk #(
   .ADDR_W(ADDR_W), .UPPER_BYPASS(UPPER_BYPASS), .SUPERVISOR(SUPERVISOR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .log_addr  (log_addr),
   .phys_addr (phys_addr),
   .xtr_req   (xtr_req),
   .xtr_wdata (xtr_wdata),
   .xtr_rdata (xtr_rdata),
   .trap_req  (trap_req),
   .rti_req   (rti_req),
   .mode_wr   (mode_wr),
   .t_mode    (t_mode),
   .t_shadow  (t_shadow),
   .priv_viol (priv_viol)
);

// File: tb/sim_task_reloc_unit.sv
`timescale 1ns/1ps
module sim_task_reloc_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_req = 1'b0, xtr_req = 1'b0, trap_req = 1'b0;
   logic        rti_req = 1'b0, mode_wr = 1'b0, mode_val = 1'b0;
   logic [31:0] log_addr = '0, xtr_wdata = '0;

   logic        preq0, preq1, t0, t1, v0, v1;
   logic [31:0] pa0, pa1, rd0, rd1;

   always #2.5 clk = ~clk;

   task_reloc_unit u0 (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .log_addr(log_addr),
      .phys_req(preq0), .phys_addr(pa0), .xtr_req(xtr_req), .xtr_wdata(xtr_wdata),
      .xtr_rdata(rd0), .trap_req(trap_req), .rti_req(rti_req), .mode_wr(mode_wr),
      .mode_val(mode_val), .t_mode(t0), .priv_viol(v0));

   task_reloc_unit #(.UPPER_BYPASS(1'b1), .SUPERVISOR(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .log_addr(log_addr),
      .phys_req(preq1), .phys_addr(pa1), .xtr_req(xtr_req), .xtr_wdata(xtr_wdata),
      .xtr_rdata(rd1), .trap_req(trap_req), .rti_req(rti_req), .mode_wr(mode_wr),
      .mode_val(mode_val), .t_mode(t1), .priv_viol(v1));

   typedef struct {
      string       tag;
      logic        preq;
      logic [31:0] phys;
      logic        t;
      logic [31:0] base;
      logic        viol;
   } exp_t;

   exp_t q0[$];
   exp_t q1[$];

   int n_run  = 0;
   int n_fail = 0;
   bit summary_done = 0;

   // bench model, one slot per instance: [0] default build, [1] both options on
   logic        m_t[2], m_sh[2], m_v[2];
   logic [31:0] m_b[2];
   bit          opt_byp[2] = '{1'b0, 1'b1};
   bit          opt_sup[2] = '{1'b0, 1'b1};

   task automatic check(input string tag, input string what, input int inst,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s u%0d %s actual=%h expected=%h", tag, inst, what, act, exp);
      end
   endtask

   task automatic print_summary();
      if (!summary_done) begin
         summary_done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      end
   endtask

   // driver: apply one cycle of inputs, queue what is due in this same cycle,
   // then advance the model over the next rising edge
   task automatic step(input string tag, input logic acc, input logic [31:0] addr,
                       input logic xtr, input logic [31:0] wd, input logic trp,
                       input logic ret, input logic mw, input logic mv);
      @(negedge clk);
      acc_req = acc; log_addr = addr; xtr_req = xtr; xtr_wdata = wd;
      trap_req = trp; rti_req = ret; mode_wr = mw; mode_val = mv;
      for (int i = 0; i < 2; i++) begin
         exp_t e;
         logic locked;
         e.tag  = tag;
         e.preq = acc;
         e.phys = (m_t[i] && !(opt_byp[i] && addr[31])) ? addr + m_b[i] : addr;
         e.t    = m_t[i];
         e.base = m_b[i];
         e.viol = m_v[i];
         if (i == 0) q0.push_back(e); else q1.push_back(e);
         locked = opt_sup[i] && m_t[i];
         m_v[i] = locked && (xtr || mw);
         if (xtr && !locked) m_b[i] = wd;
         if (trp) begin
            m_sh[i] = m_t[i];
            m_t[i]  = 1'b0;
         end else if (ret) begin
            m_t[i] = m_sh[i];
         end else if (mw && !locked) begin
            m_t[i] = mv;
         end
      end
   endtask

   task automatic compare(input exp_t e, input int inst, input logic preq,
                          input logic [31:0] pa, input logic t, input logic [31:0] rd,
                          input logic v);
      check(e.tag, "phys_req",  inst, {31'd0, preq}, {31'd0, e.preq});
      check(e.tag, "phys_addr", inst, pa, e.phys);
      check(e.tag, "t_mode",    inst, {31'd0, t}, {31'd0, e.t});
      check(e.tag, "xtr_rdata", inst, rd, e.base);
      check(e.tag, "priv_viol", inst, {31'd0, v}, {31'd0, e.viol});
   endtask

   // monitor: 1 ns after each falling edge, pop and compare
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q0.size() > 0) compare(q0.pop_front(), 0, preq0, pa0, t0, rd0, v0);
         if (q1.size() > 0) compare(q1.pop_front(), 1, preq1, pa1, t1, rd1, v1);
      end
   end

   initial begin
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      print_summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_t[i] = 0; m_sh[i] = 0; m_v[i] = 0; m_b[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values while reset is held
      check("R1", "t_mode in reset",    0, {31'd0, t0}, 32'd0);
      check("R1", "base in reset",      1, rd1, 32'd0);
      check("R1", "priv_viol in reset", 1, {31'd0, v1}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      step("R1", 1, 32'h0000_1234, 0, 0, 0, 0, 0, 0);  // R1 and R2 pass-through
      step("R2", 0, 32'h8765_4321, 0, 0, 0, 0, 0, 0);  // R2 strobe low
      step("R4", 0, 0, 1, 32'h0010_0000, 0, 0, 0, 0);  // R4 swap at T=0, no violation (R9)
      step("R7", 1, 32'h0000_0100, 0, 0, 0, 0, 1, 1);  // R7 flag write; still untranslated
      step("R3", 1, 32'h0000_0100, 0, 0, 0, 0, 0, 0);  // R3 relocated access
      step("R8", 1, 32'h8000_0010, 0, 0, 0, 0, 0, 0);  // R8 upper half: bypass only in u1
      step("R4", 1, 32'h0000_0040, 1, 32'h2000_0000, 0, 0, 0, 0);  // R4 swap at T=1, R9 in u1
      step("R4", 1, 32'h0000_0040, 0, 0, 0, 0, 0, 0);  // R4 next access uses new base; R9 pulse
      step("R9", 1, 32'h0000_0040, 0, 0, 0, 0, 1, 0);  // R9 flag write suppressed in u1
      step("R9", 1, 32'h0000_0044, 0, 0, 0, 0, 0, 0);  // R9 check suppression result
      step("R5", 1, 32'h0000_0050, 0, 0, 1, 0, 0, 0);  // R5 trap
      step("R5", 1, 32'h0000_0050, 0, 0, 0, 0, 0, 0);  // R5 T cleared, base kept
      step("R6", 0, 0, 0, 0, 0, 1, 0, 0);              // R6 return
      step("R6", 1, 32'h0000_0060, 0, 0, 0, 0, 0, 0);  // R6 restored flag
      step("R9", 0, 0, 0, 0, 0, 0, 1, 1);              // u0 enters T=1, u1 already T=1
      step("R10", 1, 32'h0000_0070, 0, 0, 1, 1, 1, 0); // R10 trap beats return and write
      step("R10", 1, 32'h0000_0070, 0, 0, 0, 0, 0, 0); // R10 T=0 in both
      step("R6", 0, 0, 0, 0, 0, 1, 1, 0);              // R6 return beats write (R10)
      step("R3", 1, 32'h2000_0010, 1, 32'hF000_0000, 0, 0, 0, 0); // swap at T=1
      step("R3", 1, 32'h2000_0010, 0, 0, 0, 0, 0, 0);  // R3 wrap in u0
      step("R3", 1, 32'hFFFF_FFF0, 0, 0, 0, 0, 0, 0);  // R3 wrap in u0, R8 bypass in u1
      step("R9", 1, 32'h0000_0000, 0, 0, 0, 0, 0, 0);  // R9 pulse lasts one cycle
      repeat (3) @(negedge clk);
      print_summary();
      $finish;
   end

endmodule